// File: doc/BRIEF.md
# Program Bank Mapper

This block sits between a CPU and its cartridge memories. It turns a CPU address into a physical location. The 32 KB program window at 0x8000-0xFFFF is split into four 8 KB slots. Each slot resolves to either a ROM bank or a work-RAM bank. A separate 8 KB work-RAM window at 0x6000-0x7FFF always reaches work RAM, through its own bank register.

A 2-bit mode sets how the four slot registers are combined. They can form one 32 KB window, two 16 KB windows, a 16 KB window followed by two 8 KB slots, or four independent 8 KB slots. Bit 7 of the resolved slot value selects ROM (1) or work RAM (0).

Work-RAM bank numbers are folded according to the RAM fitted on the board, which is a synthesis parameter. A bank with no RAM behind it raises an absent flag. The bus then returns its last value on reads and drops writes.

Top module: `prg_slot_mapper`

## Requirements
- R1: After reset, slot registers 0-2 hold 0x80, slot register 3 holds 0xFF, the mode is 3 and the work-RAM bank register holds 0. With the default 256 KB ROM, slots 0-2 read ROM bank 0 and slot 3 reads ROM bank 31.
- R2: A resolved slot value with bit 7 = 1 selects ROM. The ROM bank is bits 6:0 ANDed with (ROM_KB/8 - 1). romAddr is {bank (7 bits), cpuAddr[12:0]}.
- R3: In mode 0, slot s (cpuAddr[14:13]) resolves to register 3 with bits 1:0 replaced by s.
- R4: In mode 1, slots 0-1 resolve to register 1 and slots 2-3 to register 3. In each case bit 0 is replaced by bit 0 of the slot number.
- R5: In mode 2, slots 0-1 resolve to register 1 with bit 0 replaced by bit 0 of the slot number. Slot 2 resolves to register 2 and slot 3 to register 3, both unchanged.
- R6: In mode 3, slot s resolves to register s unchanged.
- R7: A write to slot register 3 stores the data with bit 7 forced to 1, so the top slot always reads ROM.
- R8: A work-RAM bank b (3 bits) maps according to board RAM size:
  - 8 KB: b<4 maps to bank 0; b>=4 is absent.
  - 16 KB: b maps to b>>2.
  - 32 KB: b<4 maps to b; b>=4 is absent.
  - 64 KB: b maps to b.
  - 0 KB: every bank is absent.
- R9: A RAM access to a present bank raises ramSel, with ramAddr = {mapped bank, cpuAddr[12:0]}. An access to an absent bank raises ramAbsent instead. At most one of romSel, ramSel and ramAbsent is high.
- R10: An access in 0x6000-0x7FFF never selects ROM. It uses bits 2:0 of the work-RAM bank register.
- R11: The select outputs stay low when neither cpuRd nor cpuWr is high, and for addresses below 0x6000.
- R12: Register writes (bankWr one-hot per register, modeWr, ramBankWr) take effect from the next rising clock edge. The mode keeps wrData[1:0] and the work-RAM bank keeps wrData[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankWr | input | 4 | One-hot write strobes for slot registers 0-3 |
| modeWr | input | 1 | Write strobe for the mode register |
| ramBankWr | input | 1 | Write strobe for the work-RAM bank register |
| wrData | input | 8 | Register write data |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read in progress |
| cpuWr | input | 1 | CPU write in progress |
| romAddr | output | 20 | Physical ROM byte address |
| romSel | output | 1 | Access targets ROM |
| ramAddr | output | 16 | Physical work-RAM byte address |
| ramSel | output | 1 | Access targets a present work-RAM bank |
| ramAbsent | output | 1 | Access targets a RAM bank with no memory; bus returns its last value |

## Verification
The bench drives four instances that differ only in RAM size (8, 16, 32 and 64 KB) and compares each against a behavioural model on every probe. Directed register patterns check each mode in turn:
- Values with low bits set show whether the alignment bits are really replaced.
- RAM bank values 3 and 5 separate the four size foldings and the absent holes.
- A write of 0x07 to register 3 shows whether bit 7 is forced.

A long pseudo-random mix of register writes and probes then covers mode changes in the middle of a sequence and the effect of writes on the following cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int SLOT_OFS_W = 13;
  localparam int SLOT_CNT   = 4;
  localparam int BANK_W     = 8;
  localparam int RAM_BANK_W = 3;

  typedef struct packed {
    logic [SLOT_CNT-1:0] bankWr;
    logic                modeWr;
    logic                ramBankWr;
    logic [BANK_W-1:0]   data;
  } regStrobes_t;

  typedef struct packed {
    logic       progHit;
    logic       wramHit;
    logic [1:0] slot;
  } accessInfo_t;

  // Returns {present, mapped bank} for a 3-bit RAM bank and a board size.
  function automatic logic [RAM_BANK_W:0] mapRamBank(input int ramKb,
                                                     input logic [RAM_BANK_W-1:0] bank);
    logic [RAM_BANK_W:0] r;
    r = '0;
    case (ramKb)
      8:  r = bank[2] ? 4'b0000 : 4'b1000;
      16: r = {1'b1, 2'b00, bank[2]};
      32: r = bank[2] ? 4'b0000 : {1'b1, 1'b0, bank[1:0]};
      64: r = {1'b1, bank};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prg_map_ctrl.sv
module prg_map_ctrl
  import prg_map_pkg::*;
(
  input  logic [SLOT_CNT-1:0]   bankWr,
  input  logic                  modeWr,
  input  logic                  ramBankWr,
  input  logic [BANK_W-1:0]     wrData,
  input  logic [15:0]           cpuAddr,
  input  logic                  cpuRd,
  input  logic                  cpuWr,
  output regStrobes_t           strb,
  output accessInfo_t           acc,
  output logic [SLOT_OFS_W-1:0] ofs
);

  logic active;

  always_comb begin
    strb.bankWr    = bankWr;
    strb.modeWr    = modeWr;
    strb.ramBankWr = ramBankWr;
    strb.data      = wrData;
  end

  assign active = cpuRd | cpuWr;

  always_comb begin
    acc.progHit = active & cpuAddr[15];
    acc.wramHit = active & (cpuAddr[15:13] == 3'b011);
    acc.slot    = cpuAddr[14:13];
  end

  assign ofs = cpuAddr[SLOT_OFS_W-1:0];

endmodule

// File: rtl/prg_map_datapath.sv
module prg_map_datapath
  import prg_map_pkg::*;
#(
  parameter int ROM_KB = 256,
  parameter int RAM_KB = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strb,
  input  accessInfo_t           acc,
  input  logic [SLOT_OFS_W-1:0] ofs,
  output logic [SLOT_OFS_W+6:0] romAddr,
  output logic                  romSel,
  output logic [SLOT_OFS_W+RAM_BANK_W-1:0] ramAddr,
  output logic                  ramSel,
  output logic                  ramAbsent
);

  localparam int ROM_BANKS = ROM_KB / 8;
  localparam logic [6:0] ROM_MASK = 7'(ROM_BANKS - 1);
  localparam logic [BANK_W-1:0] LOW_RESET = 8'h80;
  localparam logic [BANK_W-1:0] TOP_RESET = 8'hFF;

  logic [BANK_W-1:0]     bankQ   [SLOT_CNT];
  logic [1:0]            modeQ;
  logic [RAM_BANK_W-1:0] ramBankQ;
  logic [BANK_W-1:0]     slotVal [SLOT_CNT];
  logic [BANK_W-1:0]     selVal;
  logic [RAM_BANK_W-1:0] ramPick;
  logic [RAM_BANK_W:0]   ramMap;
  logic                  ramTarget;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOT_CNT; i++)
        bankQ[i] <= (i == SLOT_CNT-1) ? TOP_RESET : LOW_RESET;
      modeQ    <= 2'd3;
      ramBankQ <= '0;
    end else begin
      for (int i = 0; i < SLOT_CNT; i++)
        if (strb.bankWr[i])
          bankQ[i] <= (i == SLOT_CNT-1) ? (strb.data | 8'h80) : strb.data;
      if (strb.modeWr)    modeQ    <= strb.data[1:0];
      if (strb.ramBankWr) ramBankQ <= strb.data[RAM_BANK_W-1:0];
    end
  end

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    localparam logic [1:0] SI = 2'(s);
    always_comb begin
      case (modeQ)
        2'd0: slotVal[s] = {bankQ[3][7:2], SI};
        2'd1: slotVal[s] = (s < 2) ? {bankQ[1][7:1], SI[0]} : {bankQ[3][7:1], SI[0]};
        2'd2: slotVal[s] = (s < 2) ? {bankQ[1][7:1], SI[0]} : bankQ[s];
        default: slotVal[s] = bankQ[s];
      endcase
    end
  end

  assign selVal    = slotVal[acc.slot];
  assign ramPick   = acc.progHit ? selVal[RAM_BANK_W-1:0] : ramBankQ;
  assign ramMap    = mapRamBank(RAM_KB, ramPick);
  assign ramTarget = acc.wramHit | (acc.progHit & ~selVal[7]);

  assign romSel    = acc.progHit & selVal[7];
  assign ramSel    = ramTarget & ramMap[RAM_BANK_W];
  assign ramAbsent = ramTarget & ~ramMap[RAM_BANK_W];
  assign romAddr   = {selVal[6:0] & ROM_MASK, ofs};
  assign ramAddr   = {ramMap[RAM_BANK_W-1:0], ofs};

endmodule

// File: rtl/prg_slot_mapper.sv
module prg_slot_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_KB = 256,
  parameter int RAM_KB = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  bankWr,
  input  logic        modeWr,
  input  logic        ramBankWr,
  input  logic [7:0]  wrData,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRd,
  input  logic        cpuWr,
  output logic [19:0] romAddr,
  output logic        romSel,
  output logic [15:0] ramAddr,
  output logic        ramSel,
  output logic        ramAbsent
);

  regStrobes_t           strb;
  accessInfo_t           acc;
  logic [SLOT_OFS_W-1:0] ofs;

  prg_map_ctrl u_ctrl (
    .bankWr(bankWr), .modeWr(modeWr), .ramBankWr(ramBankWr), .wrData(wrData),
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .strb(strb), .acc(acc), .ofs(ofs)
  );

  prg_map_datapath #(.ROM_KB(ROM_KB), .RAM_KB(RAM_KB)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .acc(acc), .ofs(ofs),
    .romAddr(romAddr), .romSel(romSel), .ramAddr(ramAddr),
    .ramSel(ramSel), .ramAbsent(ramAbsent)
  );

endmodule

// File: rtl/prg_map_checker.sv
module prg_map_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic [19:0] romAddr,
  input logic        romSel,
  input logic [15:0] ramAddr,
  input logic        ramSel,
  input logic        ramAbsent
);

  p_excl_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel, ramAbsent}));

  p_top_rom_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd || cpuWr) && cpuAddr[15:13] == 3'b111) |-> romSel);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuRd && !cpuWr) |-> !(romSel || ramSel || ramAbsent));

  p_wram_no_rom_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] == 3'b011) |-> !romSel);

  p_ram_offset_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (ramAddr[12:0] == cpuAddr[12:0]));

  p_rom_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> (romAddr[12:0] == cpuAddr[12:0]));

endmodule

bind prg_slot_mapper prg_map_checker u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .romAddr(romAddr), .romSel(romSel), .ramAddr(ramAddr),
  .ramSel(ramSel), .ramAbsent(ramAbsent)
);

// File: tb/sim_prg_slot_mapper.sv
`timescale 1ns/1ps
module sim_prg_slot_mapper;

  localparam int ROM_BANKS = 32;
  localparam int KB [4] = '{64, 8, 16, 32};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  bankWr = '0;
  logic        modeWr = 1'b0;
  logic        ramBankWr = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;

  logic [19:0] romA [4];
  logic [15:0] ramA [4];
  logic        romS [4];
  logic        ramS [4];
  logic        absS [4];

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int mRegs [4];
  int mMode;
  int mRam;

  always #4 clk = ~clk;

  prg_slot_mapper #(.RAM_KB(64)) u0 (.clk(clk), .rstN(rstN), .bankWr(bankWr), .modeWr(modeWr),
    .ramBankWr(ramBankWr), .wrData(wrData), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .romAddr(romA[0]), .romSel(romS[0]), .ramAddr(ramA[0]), .ramSel(ramS[0]), .ramAbsent(absS[0]));
  prg_slot_mapper #(.RAM_KB(8)) u1 (.clk(clk), .rstN(rstN), .bankWr(bankWr), .modeWr(modeWr),
    .ramBankWr(ramBankWr), .wrData(wrData), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .romAddr(romA[1]), .romSel(romS[1]), .ramAddr(ramA[1]), .ramSel(ramS[1]), .ramAbsent(absS[1]));
  prg_slot_mapper #(.RAM_KB(16)) u2 (.clk(clk), .rstN(rstN), .bankWr(bankWr), .modeWr(modeWr),
    .ramBankWr(ramBankWr), .wrData(wrData), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .romAddr(romA[2]), .romSel(romS[2]), .ramAddr(ramA[2]), .ramSel(ramS[2]), .ramAbsent(absS[2]));
  prg_slot_mapper #(.RAM_KB(32)) u3 (.clk(clk), .rstN(rstN), .bankWr(bankWr), .modeWr(modeWr),
    .ramBankWr(ramBankWr), .wrData(wrData), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .romAddr(romA[3]), .romSel(romS[3]), .ramAddr(ramA[3]), .ramSel(ramS[3]), .ramAbsent(absS[3]));

  // Reference: resolved value of slot s from the mode rules (R3-R6).
  function automatic int slotBank(int s);
    case (mMode)
      0: return (mRegs[3] & 'hFC) + s;
      1: return (s < 2) ? (mRegs[1] & 'hFE) + s : (mRegs[3] & 'hFE) + (s - 2);
      2: return (s < 2) ? (mRegs[1] & 'hFE) + s : mRegs[s];
      default: return mRegs[s];
    endcase
  endfunction

  // Reference: RAM folding by board size, -1 for a hole (R8).
  function automatic int ramMap(int kb, int b);
    case (kb)
      8:  return (b < 4) ? 0 : -1;
      16: return b / 4;
      32: return (b < 4) ? b : -1;
      64: return b;
      default: return -1;
    endcase
  endfunction

  task automatic regWrite(int kind, int idx, int val);
    wrData = val[7:0];
    if (kind == 0) bankWr[idx] = 1'b1;
    else if (kind == 1) modeWr = 1'b1;
    else ramBankWr = 1'b1;
    @(posedge clk);
    if (kind == 0) mRegs[idx] = (idx == 3) ? (val | 'h80) : val;   // R7
    else if (kind == 1) mMode = val & 3;                            // R12
    else mRam = val & 7;
    @(negedge clk);
    bankWr = '0; modeWr = 1'b0; ramBankWr = 1'b0;
  endtask

  task automatic probe(int addr, bit rd, bit wr, string tag);
    bit eRom, eRam, eAbs;
    int eRomA, eRamA, bank, rb, ofs;
    cpuAddr = addr[15:0]; cpuRd = rd; cpuWr = wr;
    #2;
    ofs = addr & 'h1FFF;
    for (int d = 0; d < 4; d++) begin
      eRom = 0; eRam = 0; eAbs = 0; eRomA = 0; eRamA = 0; rb = -2;
      if (rd || wr) begin
        if (addr >= 'h8000) begin
          bank = slotBank((addr >> 13) & 3);
          if (bank & 'h80) begin
            eRom = 1;
            eRomA = (((bank & 'h7F) % ROM_BANKS) << 13) | ofs;
          end else rb = ramMap(KB[d], bank & 7);
        end else if (addr >= 'h6000) rb = ramMap(KB[d], mRam);
      end
      if (rb >= 0) begin eRam = 1; eRamA = (rb << 13) | ofs; end
      else if (rb == -1) eAbs = 1;
      vectors++;
      if (romS[d] !== eRom || ramS[d] !== eRam || absS[d] !== eAbs ||
          (eRom && romA[d] !== eRomA[19:0]) || (eRam && ramA[d] !== eRamA[15:0])) begin
        misses++;
        $display("FAIL %s ram=%0dKB addr=%h: got rom=%b/%h ram=%b/%h abs=%b exp rom=%b/%h ram=%b/%h abs=%b",
                 tag, KB[d], addr[15:0], romS[d], romA[d], ramS[d], ramA[d], absS[d],
                 eRom, eRomA[19:0], eRam, eRamA[15:0], eAbs);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    mRegs = '{'h80, 'h80, 'h80, 'hFF}; mMode = 3; mRam = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    probe('h8010, 1, 0, "R1 slot0");
    probe('hA020, 1, 0, "R1 slot1");
    probe('hE123, 1, 0, "R1 slot3");
    probe('h6044, 1, 0, "R1 wram");

    // R11: idle and out-of-window
    probe('h8000, 0, 0, "R11 idle");
    probe('h4000, 1, 0, "R11 low addr");

    // R6 / R2 / R7 in mode 3
    regWrite(0, 0, 'h02);
    regWrite(0, 1, 'h85);
    regWrite(0, 2, 'hA3);
    regWrite(0, 3, 'h07);
    probe('h8001, 1, 0, "R6 slot0 ram");
    probe('hA002, 0, 1, "R6 slot1 rom");
    probe('hC003, 1, 0, "R2 rom mask");
    probe('hE004, 1, 0, "R7 forced rom");

    // R8 / R9: size folding and holes
    regWrite(0, 0, 'h05);
    probe('h9FFF, 1, 0, "R8 bank5");
    regWrite(0, 0, 'h03);
    probe('h8ABC, 0, 1, "R8 bank3");

    // R3 mode 0
    regWrite(1, 0, 'hFC);
    regWrite(0, 3, 'h86);
    for (int s = 0; s < 4; s++) probe('h8000 + s * 'h2000 + s, 1, 0, "R3 mode0");

    // R4 mode 1
    regWrite(0, 1, 'h0B);
    regWrite(1, 0, 'h01);
    for (int s = 0; s < 4; s++) probe('h8100 + s * 'h2000, 1, 0, "R4 mode1");

    // R5 mode 2
    regWrite(0, 2, 'h06);
    regWrite(1, 0, 'hFE);
    for (int s = 0; s < 4; s++) probe('h8200 + s * 'h2000, 0, 1, "R5 mode2");

    // R10: work-RAM window register
    regWrite(2, 0, 'h0E);
    probe('h7FFF, 1, 0, "R10 wram bank6");
    regWrite(2, 0, 'hF9);
    probe('h6123, 0, 1, "R10 wram bank1");

    // R12: mixed writes and probes
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom;
      if (r[2:0] == 0) regWrite(0, r[9:8], r[23:16]);
      else if (r[2:0] == 1) regWrite(1, 0, r[23:16]);
      else if (r[2:0] == 2) regWrite(2, 0, r[23:16]);
      else probe(r[31:16], r[3], r[4] & ~r[3], "R12 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule